// File: doc/BRIEF.md
# Sampling ADC Serial Readout Controller

This block is the digital side of a sampling converter that is read over a two-wire port: a serial clock that arrives from outside and a data line that can be released. A strobe from outside starts a conversion. An internal timer then counts a fixed number of system clock cycles. When the timer runs out, the result word from a behavioural converter model is coded and placed in the output register. The reader clocks a 16-bit frame out of that register.

All inputs are sampled in one fast system clock domain. The serial clock and the convert strobe each pass through a two-flop synchronizer and an edge detector. The block keeps the output register stable while a frame is being read. If a conversion finishes during a read, the new value is held as pending and is written once the read completes, or at the next falling edge of the strobe. A flag reports whether such a deferred write is pending, so that a bench can observe it.

Top module: `adc_serial_readout`

## Requirements
- R1: A rising edge of `cnv_start` starts a conversion when none is running. `converting` then stays high for exactly `CONV_CYCLES` system cycles, and the conversion ends as it falls. A rising edge of `cnv_start` that arrives while a conversion runs has no effect on the end time.
- R2: A falling edge of `cnv_start` clears the frame bit position, releases `sdata_oe` and ends any read, but only if the synchronized `sclk` is low at that moment. While `sclk` is high, a falling edge of `cnv_start` leaves the frame position untouched, and the read continues where it stopped.
- R3: A frame is 16 bits long. The first 4 bits are 0. The 12-bit coded result follows, most significant bit first.
- R4: Each rising `sclk` edge drives the next frame bit onto `sdata` and sets `sdata_oe` to 1. The bit is meant to be sampled before the following falling `sclk` edge.
- R5: `sdata_oe` goes to 0 on the falling `sclk` edge that follows the 16th rising edge of a frame. That edge completes the read.
- R6: A rising `sclk` edge after the 16th restarts the frame at its first bit. After such a restart, `sdata_oe` stays 1 when `sclk` stops.
- R7: If a conversion ends while a read is in progress, `out_reg` keeps its old value, and `update_pending` is 1 until the new value is written when the read completes.
- R8: If a read is still unfinished at the next falling edge of `cnv_start`, the pending value is written on that edge and `update_pending` returns to 0. When `sclk` is low, the frame position is reset as well.
- R9: When `fmt_twos` is 1 at the end of a conversion, the most significant bit of the offset-binary `conv_result` is inverted, which gives twos complement. When `fmt_twos` is 0, the result is stored unchanged as straight binary.
- R10: After reset, `sdata`, `sdata_oe`, `converting` and `update_pending` are 0, and the output register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_start | input | 1 | Convert strobe (asynchronous) |
| sclk | input | 1 | Serial read clock (asynchronous) |
| conv_result | input | 12 | Offset-binary result from the converter model |
| fmt_twos | input | 1 | 1 selects twos complement coding |
| sdata | output | 1 | Serial frame data |
| sdata_oe | output | 1 | Data line driven (0 means released) |
| converting | output | 1 | Conversion timer running |
| update_pending | output | 1 | Deferred output register write waiting |

## Verification
A wrong frame position shows on `sdata` at the next rising serial clock, three system cycles later. It also shows on `sdata_oe`, which releases after the wrong falling edge. A wrong pending state shows up either as `update_pending` disagreeing with the reference for a whole read, or as a stale or early value in the next frame. A fault in the timer moves the falling edge of `converting`, which is visible in the same cycle. Per-cycle comparison against a behavioural model catches each of these in the cycle where it first appears. Directed reads of whole frames confirm the data that an external reader would capture.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    localparam int RES_W   = 12;
    localparam int FRAME_W = 16;
    localparam int LEAD_W  = FRAME_W - RES_W;

    typedef logic [RES_W-1:0]   code_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef struct packed {
        logic  valid;
        code_t data;
    } pend_t;

    function automatic code_t encode(code_t raw, logic twos);
        code_t c;
        c = raw;
        if (twos) c[RES_W-1] = ~raw[RES_W-1];
        return c;
    endfunction

    function automatic frame_t build_frame(code_t c);
        return {{LEAD_W{1'b0}}, c};
    endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R4
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CYCLES = 1500
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int TW = $clog2(CYCLES + 1);
    logic [TW-1:0] remain;
    logic [TW:0]   run;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            remain <= TW'(CYCLES - 1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    assign done = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    AST_CONV_LEN: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < (TW+1)'(CYCLES))); // R1
    AST_CONV_FULL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(run) == (TW+1)'(CYCLES - 1))); // R1
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import adc_rd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_rise,
    input  logic   sclk_fall,
    input  logic   sclk_level,
    input  logic   cnv_fall,
    input  frame_t frame_i,
    output logic   sdata,
    output logic   oe,
    output logic   rd_active,
    output logic   rd_done
);
    localparam int CW = $clog2(FRAME_W + 1);
    localparam int IW = $clog2(FRAME_W);

    logic [CW-1:0] rcnt;
    logic [CW-1:0] nxt;
    logic [IW-1:0] idx;
    logic          clear;
    logic          at_end;

    assign clear  = cnv_fall && !sclk_level;
    assign at_end = (rcnt == CW'(FRAME_W));
    assign nxt    = at_end ? CW'(1) : rcnt + 1'b1;
    assign idx    = IW'(FRAME_W - int'(nxt));
    assign rd_done = sclk_fall && at_end && rd_active;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rcnt      <= '0;
            oe        <= 1'b0;
            sdata     <= 1'b0;
            rd_active <= 1'b0;
        end else if (sclk_rise) begin
            rcnt      <= nxt;
            sdata     <= frame_i[idx];
            oe        <= 1'b1;
            rd_active <= 1'b1;
        end else if (sclk_fall && at_end) begin
            oe        <= 1'b0;
            sdata     <= 1'b0;
            rd_active <= 1'b0;
        end
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear |=> (rcnt == '0 && !oe)); // R2
    AST_OE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && !clear) |=> oe); // R4
    AST_OE_OFF_LAST: assert property (@(posedge clk) disable iff (rst)
        (sclk_fall && at_end && !sclk_rise && !clear) |=> !oe); // R5
    AST_OE_HAS_POS: assert property (@(posedge clk) disable iff (rst)
        oe |-> (rcnt != '0)); // R6
endmodule

// File: rtl/adc_serial_readout.sv
module adc_serial_readout
    import adc_rd_pkg::*;
#(
    parameter int CONV_CYCLES = 1500,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnv_start,
    input  logic             sclk,
    input  logic [RES_W-1:0] conv_result,
    input  logic             fmt_twos,
    output logic             sdata,
    output logic             sdata_oe,
    output logic             converting,
    output logic             update_pending
);
    logic  s_lvl, s_rise, s_fall;
    logic  c_lvl, c_rise, c_fall;
    logic  t_done, rd_active, rd_done, read_busy;
    code_t out_reg, code_now;
    pend_t pend;

    edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
        .clk(clk), .rst(rst), .din(sclk),
        .level(s_lvl), .rise(s_rise), .fall(s_fall));

    edge_sync #(.STAGES(SYNC_STAGES)) u_cnv_sync (
        .clk(clk), .rst(rst), .din(cnv_start),
        .level(c_lvl), .rise(c_rise), .fall(c_fall));

    conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(c_rise),
        .busy(converting), .done(t_done));

    frame_shifter u_shift (
        .clk(clk), .rst(rst),
        .sclk_rise(s_rise), .sclk_fall(s_fall), .sclk_level(s_lvl),
        .cnv_fall(c_fall), .frame_i(build_frame(out_reg)),
        .sdata(sdata), .oe(sdata_oe),
        .rd_active(rd_active), .rd_done(rd_done));

    assign code_now  = encode(conv_result, fmt_twos);
    assign read_busy = rd_active && !rd_done && !c_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_reg <= '0;
            pend    <= '0;
        end else if (t_done) begin
            if (read_busy) pend <= '{valid: 1'b1, data: code_now};
            else           out_reg <= code_now;
        end else if (pend.valid && (rd_done || c_fall)) begin
            out_reg    <= pend.data;
            pend.valid <= 1'b0;
        end
    end

    assign update_pending = pend.valid;

    AST_PEND_IN_READ: assert property (@(posedge clk) disable iff (rst)
        pend.valid |-> rd_active); // R7
    AST_OUT_HOLD_READ: assert property (@(posedge clk) disable iff (rst)
        read_busy |=> $stable(out_reg)); // R7
    AST_FLUSH_ON_CNV: assert property (@(posedge clk) disable iff (rst)
        (c_fall && !t_done) |=> !pend.valid); // R8
endmodule

// File: tb/adc_serial_readout_tb.sv
module adc_serial_readout_tb;
    localparam int CYC = 1500;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnv_start = 1'b0;
    logic        sclk = 1'b0;
    logic [11:0] conv_result = 12'h000;
    logic        fmt_twos = 1'b0;
    logic        sdata, sdata_oe, converting, update_pending;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adc_serial_readout #(.CONV_CYCLES(CYC)) u_dut (
        .clk(clk), .rst(rst), .cnv_start(cnv_start), .sclk(sclk),
        .conv_result(conv_result), .fmt_twos(fmt_twos),
        .sdata(sdata), .sdata_oe(sdata_oe),
        .converting(converting), .update_pending(update_pending));

    // behavioural reference model
    int  hs[4];
    int  hc[4];
    int  m_cnt, m_rem;
    bit  m_oe, m_sd, m_rd, m_busy, m_pv;
    int  m_out, m_pd;
    bit  model_on = 0;

    always @(posedge clk) begin
        int  frame, code, n;
        bit  rs, fs, rc, fc, lv, tdone, rdone, rbusy;
        for (int i = 3; i > 0; i--) begin hs[i] = hs[i-1]; hc[i] = hc[i-1]; end
        hs[0] = sclk; hc[0] = cnv_start;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin hs[i] = 0; hc[i] = 0; end
            m_cnt = 0; m_rem = 0; m_oe = 0; m_sd = 0; m_rd = 0;
            m_busy = 0; m_pv = 0; m_out = 0; m_pd = 0;
        end else begin
            lv = hs[2] != 0;
            rs = hs[2] != 0 && hs[3] == 0;
            fs = hs[2] == 0 && hs[3] != 0;
            rc = hc[2] != 0 && hc[3] == 0;
            fc = hc[2] == 0 && hc[3] != 0;
            tdone = m_busy && m_rem == 0;
            rdone = fs && m_cnt == 16 && m_rd;
            rbusy = m_rd && !rdone && !fc;
            code  = fmt_twos ? (conv_result ^ 12'h800) : conv_result;
            frame = m_out;
            if (tdone) begin
                if (rbusy) begin m_pv = 1; m_pd = code; end
                else m_out = code;
            end else if (m_pv && (rdone || fc)) begin
                m_out = m_pd; m_pv = 0;
            end
            if (fc && !lv) begin
                m_cnt = 0; m_oe = 0; m_sd = 0; m_rd = 0;
            end else if (rs) begin
                n = (m_cnt == 16) ? 1 : m_cnt + 1;
                m_cnt = n; m_sd = (frame >> (16 - n)) & 1; m_oe = 1; m_rd = 1;
            end else if (fs && m_cnt == 16) begin
                m_oe = 0; m_sd = 0; m_rd = 0;
            end
            if (rc && !m_busy) begin m_busy = 1; m_rem = CYC - 1; end
            else if (m_busy) begin
                if (m_rem == 0) m_busy = 0; else m_rem = m_rem - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (model_on && !rst) begin
            checks++;
            if (sdata_oe !== m_oe) begin errors++; $display("FAIL R5 oe act=%0b exp=%0b t=%0t", sdata_oe, m_oe, $time); end
            else if (sdata !== m_sd) begin errors++; $display("FAIL R4 sdata act=%0b exp=%0b t=%0t", sdata, m_sd, $time); end
            else if (update_pending !== m_pv) begin errors++; $display("FAIL R7 pending act=%0b exp=%0b t=%0t", update_pending, m_pv, $time); end
            else if (converting !== m_busy) begin errors++; $display("FAIL R1 converting act=%0b exp=%0b t=%0t", converting, m_busy, $time); end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_cnv();
        cnv_start = 1'b1; tick(2); cnv_start = 1'b0; tick(4);
    endtask

    task automatic read_bits(input int n, inout logic [15:0] w);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1; tick(4);
            check("R4 oe while clocking", sdata_oe, 1);
            w = {w[14:0], sdata};
            sclk = 1'b0; tick(4);
        end
    endtask

    task automatic convert(input logic [11:0] raw, input logic twos);
        conv_result = raw; fmt_twos = twos;
        pulse_cnv(); tick(CYC + 10);
    endtask

    initial begin
        logic [15:0] w;
        tick(5);
        rst = 1'b0;
        @(negedge clk);
        check("R10 sdata", sdata, 0);
        check("R10 oe", sdata_oe, 0);
        check("R10 converting", converting, 0);
        check("R10 pending", update_pending, 0);
        model_on = 1;
        w = '0; read_bits(16, w);
        check("R10 reset register frame", w, 16'h0000);
        tick(4);

        // R1: conversion length, restart ignored
        conv_result = 12'h5A3; fmt_twos = 1'b0;
        pulse_cnv();
        check("R1 converting after start", converting, 1);
        tick(100); pulse_cnv();
        tick(CYC - 122);
        check("R1 still converting", converting, 1);
        tick(15);
        check("R1 converting ended, restart ignored", converting, 0);

        // R3 / R5 straight frame
        w = '0; read_bits(16, w);
        check("R3 frame straight", w, 16'h05A3);
        check("R5 oe released after 16th fall", sdata_oe, 0);

        // R9 twos complement
        convert(12'h123, 1'b1);
        w = '0; read_bits(16, w);
        check("R9 twos complement frame", w, 16'h0923);
        convert(12'h923, 1'b0);
        w = '0; read_bits(16, w);
        check("R9 straight binary frame", w, 16'h0923);

        // R7 deferred update
        conv_result = 12'hABC; fmt_twos = 1'b0;
        pulse_cnv();
        w = '0; read_bits(8, w);
        tick(CYC);
        check("R7 pending during read", update_pending, 1);
        read_bits(8, w);
        check("R7 old frame kept", w, 16'h0923);
        check("R7 pending cleared", update_pending, 0);
        w = '0; read_bits(16, w);
        check("R7 new value after read", w, 16'h0ABC);

        // R8 unfinished read flushed by strobe fall
        conv_result = 12'h0F1;
        pulse_cnv();
        w = '0; read_bits(4, w);
        tick(CYC);
        check("R8 pending before strobe", update_pending, 1);
        pulse_cnv();
        check("R8 pending flushed", update_pending, 0);
        check("R8 oe released by reset", sdata_oe, 0);
        w = '0; read_bits(16, w);
        check("R8 fresh frame from start", w, 16'h00F1);
        tick(CYC + 10);

        // R6 wrap
        w = '0; read_bits(16, w);
        check("R6 base frame", w, 16'h00F1);
        w = '0; read_bits(2, w);
        check("R6 wrapped leading bits", w, 16'h0000);
        tick(20);
        check("R6 oe stays after stop", sdata_oe, 1);

        // R2 strobe fall with sclk low clears
        pulse_cnv();
        check("R2 clear with sclk low", sdata_oe, 0);
        tick(CYC + 10);

        // R2 strobe fall with sclk high does not clear
        w = '0; read_bits(3, w);
        sclk = 1'b1; tick(4);
        w = {w[14:0], sdata};
        pulse_cnv();
        sclk = 1'b0; tick(4);
        check("R2 oe kept with sclk high", sdata_oe, 1);
        read_bits(12, w);
        check("R2 frame continues", w, 16'h00F1);
        tick(CYC + 10);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule